// File: doc/BRIEF.md
# SPI Flash Transaction Engine

This block runs one complete serial-flash transaction from a small descriptor. The host fills in the descriptor through a word-wide register port. It holds up to five command bytes, a mask that says which of those bytes the master drives, a local-memory base address, a transmit byte count and a receive byte count. Writing the launch bit then starts the transaction. The engine lowers chip select and clocks out the command bytes. It then streams the transmit bytes, which it reads from local memory starting at the base address. Last, it clocks in the receive bytes and stores them into local memory right after the transmitted region. When all of this is finished it releases chip select and sets a completion flag, which the host polls.

The serial side is a single-lane master in clock mode 0, most significant bit first. The serial clock is derived from the system clock by a fixed parameter. Local memory is reached through a byte-wide synchronous port with one cycle of read latency.

The control state machine has these states:
- `S_IDLE`: waits for a launch.
- `S_CMD_GO` and `S_CMD_WAIT`: start each command byte and wait for it to finish.
- `S_TX_RD`, `S_TX_GO` and `S_TX_WAIT`: read a memory byte, start shifting it, and wait for the shift to finish.
- `S_RX_GO`, `S_RX_WAIT` and `S_RX_PUT`: start a receive byte, wait for it, and write it to memory.
- `S_CLOSE`: releases chip select and sets the completion flag.

The transitions are:
- `S_IDLE` goes to `S_CMD_GO` on launch.
- `S_CMD_GO` goes to `S_CMD_WAIT`.
- `S_CMD_WAIT` goes back to `S_CMD_GO` while command bytes remain. After the last command byte it goes to `S_TX_RD` if the transmit count is nonzero, else to `S_RX_GO` if the receive count is nonzero, else to `S_CLOSE`.
- `S_TX_RD` goes to `S_TX_GO`, and `S_TX_GO` goes to `S_TX_WAIT`.
- `S_TX_WAIT` goes to `S_TX_RD` while transmit bytes remain, then to `S_RX_GO` or `S_CLOSE` by the same rule as above.
- `S_RX_GO` goes to `S_RX_WAIT`, and `S_RX_WAIT` goes to `S_RX_PUT`.
- `S_RX_PUT` goes to `S_RX_GO` while receive bytes remain, else to `S_CLOSE`.
- `S_CLOSE` goes to `S_IDLE`.

Top module: `sfx_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `mem_en` is 0 and the completion register reads 0.
- R2: The register offsets are: 0x04 command control, with bits 2:0 the command byte count, bits 27:8 the 20-bit transmit count, and bit 7 the launch bit (which always reads 0). 0x08 is the 20-bit receive count. 0x0C holds command bytes 0 to 3, with byte 0 in bits 7:0. 0x10 holds command byte 4 in bits 7:0. 0x14 is the 5-bit drive mask. 0x18 is the completion flag in bit 0. 0x1C is the 32-bit memory base. Offset 0x00 reads 0. Each field reads back what was last written.
- R3: A write to 0x04 with bit 7 set while idle launches a transaction, and the completion flag reads 0 from the cycle after that write.
- R4: The command phase sends command bytes 0 upward, as many as the count field gives. A count of 0 is treated as 1, and a count above 5 is treated as 5.
- R5: Serial clock mode 0, MSB first. `spi_sclk` idles low and has a period of 2·HALF_DIV system clocks. MOSI never changes on a rising serial clock edge.
- R6: `spi_mosi_oe` is high during command byte i exactly when drive-mask bit i is 1. It is high during transmit bytes and low during receive bytes. `spi_mosi` is 0 whenever `spi_mosi_oe` is 0.
- R7: The transmit phase reads exactly transmit-count bytes from consecutive memory addresses starting at the base, and shifts them out after the command bytes.
- R8: The receive phase shifts in exactly receive-count bytes, assembled MSB first. It writes them to consecutive memory addresses starting at base plus transmit count. No memory write happens while `spi_cs_n` is high.
- R9: `spi_cs_n` is low across every serial clock edge of the transaction. It is high again before the completion flag reads 1, and the flag is 0 while `spi_cs_n` is low.
- R10: While a transaction runs, register writes (including another launch) are ignored: the registers keep their values and no extra serial clocks occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_en | output | 1 | Local memory access enable |
| mem_we | output | 1 | Local memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Local memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with HALF_DIV = 1, so a byte takes only 16 system clocks and transactions of up to eleven bytes finish quickly. It also uses ADDR_W = 12, so the bench models the whole local memory as a plain array and can check transmitted and received bytes against memory contents directly. With these values the bench covers every phase combination: command only, command with receive, command with transmit, and all three together. It also covers count clamping at both ends, a partial drive mask, and a launch attempted during a busy transaction.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
    // register byte offsets seen by the host
    localparam logic [4:0] OFS_MODE   = 5'h00;
    localparam logic [4:0] OFS_CMD    = 5'h04;
    localparam logic [4:0] OFS_RXN    = 5'h08;
    localparam logic [4:0] OFS_BUF_LO = 5'h0C;
    localparam logic [4:0] OFS_BUF_HI = 5'h10;
    localparam logic [4:0] OFS_DIR    = 5'h14;
    localparam logic [4:0] OFS_DONE   = 5'h18;
    localparam logic [4:0] OFS_BASE   = 5'h1C;

    localparam int MAX_CMD   = 5;
    localparam int START_BIT = 7;
    localparam int TXN_LSB   = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD_GO, S_CMD_WAIT, S_TX_RD, S_TX_GO, S_TX_WAIT,
        S_RX_GO, S_RX_WAIT, S_RX_PUT, S_CLOSE
    } eng_state_e;
endpackage

// File: rtl/sfx_regs.sv
module sfx_regs
    import sfx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [4:0]           addr,
    input  logic [31:0]          wdata,
    input  logic                 engine_busy,
    input  logic                 set_done,
    output logic                 launch,
    output logic                 done_flag,
    output logic [2:0]           ncmd,
    output logic [CNT_W-1:0]     tx_cnt,
    output logic [CNT_W-1:0]     rx_cnt,
    output logic [8*MAX_CMD-1:0] cmd_bytes,
    output logic [MAX_CMD-1:0]   dir_mask,
    output logic [ADDR_W-1:0]    base,
    output logic [31:0]          rdata
);
    logic [31:0] buf_lo;
    logic [7:0]  buf_hi;
    logic [31:0] base_q;
    logic        busy;
    logic        wr_ok;
    logic        start_hit;

    assign busy      = engine_busy | launch;
    assign wr_ok     = wr_en & ~busy;
    assign start_hit = wr_ok && (addr == OFS_CMD) && wdata[START_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ncmd      <= '0;
            tx_cnt    <= '0;
            rx_cnt    <= '0;
            buf_lo    <= '0;
            buf_hi    <= '0;
            dir_mask  <= '0;
            base_q    <= '0;
            launch    <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            launch <= start_hit;
            if (start_hit)     done_flag <= 1'b0;
            else if (set_done) done_flag <= 1'b1;
            if (wr_ok) begin
                unique case (addr)
                    OFS_CMD: begin
                        ncmd   <= wdata[2:0];
                        tx_cnt <= wdata[TXN_LSB +: CNT_W];
                    end
                    OFS_RXN:    rx_cnt   <= wdata[CNT_W-1:0];
                    OFS_BUF_LO: buf_lo   <= wdata;
                    OFS_BUF_HI: buf_hi   <= wdata[7:0];
                    OFS_DIR:    dir_mask <= wdata[MAX_CMD-1:0];
                    OFS_BASE:   base_q   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign cmd_bytes = {buf_hi, buf_lo};
    assign base      = base_q[ADDR_W-1:0];

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_MODE:   rdata = '0;
            OFS_CMD: begin
                rdata[2:0]                = ncmd;
                rdata[TXN_LSB +: CNT_W]   = tx_cnt;
            end
            OFS_RXN:    rdata[CNT_W-1:0]   = rx_cnt;
            OFS_BUF_LO: rdata              = buf_lo;
            OFS_BUF_HI: rdata[7:0]         = buf_hi;
            OFS_DIR:    rdata[MAX_CMD-1:0] = dir_mask;
            OFS_DONE:   rdata[0]           = done_flag;
            OFS_BASE:   rdata              = base_q;
            default:    rdata              = '0;
        endcase
    end
endmodule

// File: rtl/sfx_shift.sv
module sfx_shift #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic             active;
    logic [DIV_W-1:0] div;
    logic [2:0]       bitc;
    logic [7:0]       sreg;
    logic             tick;

    assign tick = (div == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div     <= '0;
            bitc    <= '0;
            sreg    <= '0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sreg   <= tx_byte;
                bitc   <= '0;
                div    <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (tick) begin
                    div <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitc == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bitc <= bitc + 3'd1;
                            sreg <= {sreg[6:0], 1'b0};
                        end
                    end
                end else begin
                    div <= div + DIV_W'(1);
                end
            end
        end
    end

    assign mosi = sreg[7];
endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
    import sfx_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 20,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    output logic              spi_mosi_oe,
    input  logic              spi_miso
);
    localparam int CMD_W = 8 * MAX_CMD;

    eng_state_e         st, st_nx;
    logic               launch, done_flag, engine_busy;
    logic [2:0]         ncmd, nbytes, idx;
    logic [CNT_W-1:0]   tx_cnt, rx_cnt, tx_left, rx_left;
    logic [CMD_W-1:0]   cmd_bytes;
    logic [MAX_CMD-1:0] dir_mask;
    logic [ADDR_W-1:0]  base, ptr;
    logic               oe_q;
    logic               sh_go, sh_done, sh_mosi;
    logic [7:0]         sh_byte, sh_rx, cmd_sel;
    logic               last_cmd;

    assign engine_busy = (st != S_IDLE);

    sfx_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .engine_busy(engine_busy),
        .set_done(st == S_CLOSE), .launch(launch), .done_flag(done_flag),
        .ncmd(ncmd), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .cmd_bytes(cmd_bytes), .dir_mask(dir_mask), .base(base),
        .rdata(reg_rdata)
    );

    sfx_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_byte),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(sh_mosi),
        .done(sh_done), .rx_byte(sh_rx)
    );

    assign nbytes   = (ncmd == 3'd0) ? 3'd1 :
                      (ncmd > 3'(MAX_CMD)) ? 3'(MAX_CMD) : ncmd;
    assign last_cmd = (idx == nbytes - 3'd1);
    assign cmd_sel  = cmd_bytes[6'({idx, 3'b000}) +: 8];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:     if (launch) st_nx = S_CMD_GO;
            S_CMD_GO:   st_nx = S_CMD_WAIT;
            S_CMD_WAIT: if (sh_done) begin
                            if (!last_cmd)           st_nx = S_CMD_GO;
                            else if (tx_left != '0)  st_nx = S_TX_RD;
                            else if (rx_left != '0)  st_nx = S_RX_GO;
                            else                     st_nx = S_CLOSE;
                        end
            S_TX_RD:    st_nx = S_TX_GO;
            S_TX_GO:    st_nx = S_TX_WAIT;
            S_TX_WAIT:  if (sh_done) begin
                            if (tx_left != '0)       st_nx = S_TX_RD;
                            else if (rx_left != '0)  st_nx = S_RX_GO;
                            else                     st_nx = S_CLOSE;
                        end
            S_RX_GO:    st_nx = S_RX_WAIT;
            S_RX_WAIT:  if (sh_done) st_nx = S_RX_PUT;
            S_RX_PUT:   st_nx = (rx_left == CNT_W'(1)) ? S_CLOSE : S_RX_GO;
            S_CLOSE:    st_nx = S_IDLE;
            default:    st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        spi_cs_n  = (st == S_IDLE) || (st == S_CLOSE);
        sh_go     = 1'b0;
        sh_byte   = 8'h00;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = sh_rx;
        unique case (st)
            S_CMD_GO: begin sh_go = 1'b1; sh_byte = cmd_sel;   end
            S_TX_RD:  mem_en = 1'b1;
            S_TX_GO:  begin sh_go = 1'b1; sh_byte = mem_rdata; end
            S_RX_GO:  sh_go = 1'b1;
            S_RX_PUT: begin mem_en = 1'b1; mem_we = 1'b1;      end
            default: ;
        endcase
    end

    assign spi_mosi    = sh_mosi & oe_q;
    assign spi_mosi_oe = oe_q;

    // datapath counters and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            tx_left <= '0;
            rx_left <= '0;
            ptr     <= '0;
            oe_q    <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (launch) begin
                    idx     <= '0;
                    tx_left <= tx_cnt;
                    rx_left <= rx_cnt;
                    ptr     <= base;
                end
                S_CMD_GO:   oe_q <= dir_mask[idx];
                S_CMD_WAIT: if (sh_done) idx <= idx + 3'd1;
                S_TX_GO: begin
                    oe_q    <= 1'b1;
                    ptr     <= ptr + ADDR_W'(1);
                    tx_left <= tx_left - CNT_W'(1);
                end
                S_RX_GO:    oe_q <= 1'b0;
                S_RX_PUT: begin
                    ptr     <= ptr + ADDR_W'(1);
                    rx_left <= rx_left - CNT_W'(1);
                end
                S_CLOSE:    oe_q <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sfx_engine_chk.sv
module sfx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic mem_en,
    input logic mem_we,
    input logic done_flag,
    input logic launch
);
    // R5: serial clock idles low outside the transaction
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R5: data out never moves on a rising serial clock
    a_r5_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R8: memory writes only inside the select window
    a_r8_write_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> !spi_cs_n);

    // R9: completion only after select is released
    a_r9_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (spi_cs_n && $past(spi_cs_n)));

    // R9: flag stays clear while the device is selected
    a_r9_no_done_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !done_flag);

    // R3: an accepted launch selects the device on the next cycle
    a_r3_launch_selects: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !spi_cs_n);
endmodule

bind sfx_engine sfx_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .mem_en(mem_en), .mem_we(mem_we),
    .done_flag(done_flag), .launch(launch)
);

// File: tb/sfx_engine_bench.sv
module sfx_engine_bench;
    import sfx_pkg::*;

    localparam int  ADDR_W   = 12;
    localparam int  CNT_W    = 20;
    localparam int  HALF_DIV = 1;
    localparam time CLK_P    = 4ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;
    logic              spi_sclk, spi_cs_n, spi_mosi, spi_mosi_oe, spi_miso;

    always #(CLK_P/2) clk = ~clk;

    sfx_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_sfx_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // local memory model
    logic [7:0] mem [0:(1<<ADDR_W)-1];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    // flash device model: byte k after select falls answers resp(k)
    function automatic logic [7:0] resp(input int k);
        return 8'(k * 29) ^ 8'h3C;
    endfunction
    int         sk = 0, sb = 0;
    logic [7:0] cur_resp;
    always @(negedge spi_cs_n) begin sk = 0; sb = 0; end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        sb++;
        if (sb == 8) begin sb = 0; sk++; end
    end
    assign cur_resp = resp(sk);
    assign spi_miso = cur_resp[3'(7 - sb)];

    // scoreboards
    typedef struct packed { logic [ADDR_W-1:0] a; logic [7:0] d; } wr_t;
    logic [7:0] exp_bytes[$];
    wr_t        exp_wr[$];
    int   edge_cnt = 0, cs_err = 0, undriven_hi = 0, nb = 0;
    logic [7:0] sh_bits = '0;
    logic       byte_oe = 1'b0;
    time  t_prev = 0, period = 0;

    // serial monitor: bytes driven by the master are compared in order
    always @(posedge spi_sclk) begin
        edge_cnt++;
        if (spi_cs_n) cs_err++;
        if (edge_cnt > 1) period = $time - t_prev;
        t_prev  = $time;
        sh_bits = {sh_bits[6:0], spi_mosi};
        byte_oe = spi_mosi_oe;
        if (!spi_mosi_oe && spi_mosi) undriven_hi++;
        nb++;
        if (nb == 8) begin
            nb = 0;
            if (byte_oe) begin
                if (exp_bytes.size() == 0) chk(0, "R6 unexpected driven byte", {24'h0, sh_bits}, 32'h0);
                else begin
                    logic [7:0] e;
                    e = exp_bytes.pop_front();
                    chk(sh_bits == e, "R4/R7 driven byte", {24'h0, sh_bits}, {24'h0, e});
                end
            end
        end
    end

    // memory write monitor
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            if (exp_wr.size() == 0) chk(0, "R8 unexpected write", {20'h0, mem_addr}, 32'h0);
            else begin
                wr_t e;
                e = exp_wr.pop_front();
                chk({mem_addr, mem_wdata} == {e.a, e.d}, "R8 write addr/data",
                    32'({mem_addr, mem_wdata}), 32'({e.a, e.d}));
            end
        end
    end

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1ns;
        v = reg_rdata;
    endtask

    task automatic run_txn(input logic [2:0] nfield, input logic [31:0] lo, input logic [7:0] hi,
                           input logic [4:0] mask, input int tx, input int rx,
                           input logic [ADDR_W-1:0] base, input bit poke);
        int n;
        logic [39:0] cb;
        logic [31:0] v;
        bit seen;
        n  = (nfield == 0) ? 1 : (nfield > 5) ? 5 : int'(nfield);
        cb = {hi, lo};
        for (int i = 0; i < n; i++) if (mask[i]) exp_bytes.push_back(cb[i*8 +: 8]);
        for (int j = 0; j < tx; j++) exp_bytes.push_back(mem[base + ADDR_W'(j)]);
        for (int j = 0; j < rx; j++) begin
            wr_t w;
            w.a = base + ADDR_W'(tx + j);
            w.d = resp(n + tx + j);
            exp_wr.push_back(w);
        end
        reg_write(OFS_BUF_LO, lo);
        reg_write(OFS_BUF_HI, {24'h0, hi});
        reg_write(OFS_DIR, {27'h0, mask});
        reg_write(OFS_RXN, 32'(rx));
        reg_write(OFS_BASE, 32'(base));
        edge_cnt = 0; cs_err = 0; undriven_hi = 0; nb = 0;
        reg_write(OFS_CMD, (32'(tx) << 8) | 32'h80 | 32'(nfield));
        reg_read(OFS_DONE, v);
        chk(v[0] == 1'b0, "R3 done cleared by launch", v, 32'h0);
        if (poke) begin
            repeat (20) @(negedge clk);
            reg_write(OFS_BUF_LO, 32'hDEAD0000);
            reg_write(OFS_CMD, 32'h0000_0081);
        end
        seen = 0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk);
            reg_read(OFS_DONE, v);
            if (v[0]) seen = 1;
        end
        chk(seen, "R3 completion flag", {31'h0, seen}, 32'h1);
        chk(spi_cs_n == 1'b1, "R9 select released at done", {31'h0, spi_cs_n}, 32'h1);
        chk(cs_err == 0, "R9 clock edges inside select", cs_err, 0);
        chk(undriven_hi == 0, "R6 mosi low when not driven", undriven_hi, 0);
        chk(edge_cnt == 8 * (n + tx + rx), "R4/R10 serial clock count", edge_cnt, 8 * (n + tx + rx));
        chk(exp_bytes.size() == 0, "R6/R7 all driven bytes seen", exp_bytes.size(), 0);
        chk(exp_wr.size() == 0, "R8 all writes seen", exp_wr.size(), 0);
        if (poke) begin
            reg_read(OFS_BUF_LO, v);
            chk(v == lo, "R10 write while busy ignored", v, lo);
            reg_read(OFS_CMD, v);
            chk(v == ((32'(tx) << 8) | 32'(nfield)), "R10 launch while busy ignored", v,
                (32'(tx) << 8) | 32'(nfield));
        end
        exp_bytes.delete();
        exp_wr.delete();
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'h00;
        for (int j = 0; j < 8; j++) mem[12'h100 + 12'(j)] = 8'h50 + 8'(j * 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(spi_cs_n == 1'b1, "R1 cs_n after reset", {31'h0, spi_cs_n}, 32'h1);
        chk(spi_sclk == 1'b0, "R1 sclk after reset", {31'h0, spi_sclk}, 32'h0);
        chk(mem_en == 1'b0, "R1 mem_en after reset", {31'h0, mem_en}, 32'h0);
        reg_read(OFS_DONE, v);
        chk(v == 32'h0, "R1 done after reset", v, 32'h0);
        // R2 readback
        reg_write(OFS_CMD, 32'h0ABC_DE05);
        reg_read(OFS_CMD, v);    chk(v == 32'h0ABC_DE05, "R2 cmd control", v, 32'h0ABC_DE05);
        reg_write(OFS_RXN, 32'hFFF1_2345);
        reg_read(OFS_RXN, v);    chk(v == 32'h0001_2345, "R2 receive count", v, 32'h0001_2345);
        reg_write(OFS_BUF_LO, 32'h1122_3344);
        reg_read(OFS_BUF_LO, v); chk(v == 32'h1122_3344, "R2 command bytes 0-3", v, 32'h1122_3344);
        reg_write(OFS_BUF_HI, 32'hAABB_CC99);
        reg_read(OFS_BUF_HI, v); chk(v == 32'h99, "R2 command byte 4", v, 32'h99);
        reg_write(OFS_DIR, 32'hFF);
        reg_read(OFS_DIR, v);    chk(v == 32'h1F, "R2 drive mask", v, 32'h1F);
        reg_write(OFS_BASE, 32'h1234_5678);
        reg_read(OFS_BASE, v);   chk(v == 32'h1234_5678, "R2 memory base", v, 32'h1234_5678);
        reg_read(OFS_MODE, v);   chk(v == 32'h0, "R2 offset 0 reads 0", v, 32'h0);
        reg_read(OFS_DONE, v);   chk(v == 32'h0, "R2 no launch without bit 7", v, 32'h0);

        run_txn(3'd1, 32'h0000_0005, 8'h00, 5'h01, 0, 4, 12'h200, 0);  // R8 opcode + receive
        chk(period == 2 * HALF_DIV * CLK_P, "R5 serial clock period", 32'(period), 32'(2 * HALF_DIV * CLK_P));
        run_txn(3'd5, 32'h5634_120B, 8'hA5, 5'h1F, 0, 6, 12'h300, 0);  // R4 five bytes
        run_txn(3'd4, 32'h0010_0002, 8'h00, 5'h0F, 5, 0, 12'h100, 0);  // R7 transmit
        run_txn(3'd3, 32'h00C0_B0A0, 8'h00, 5'h05, 0, 0, 12'h000, 0);  // R6 partial mask
        run_txn(3'd0, 32'h0000_0006, 8'h00, 5'h01, 0, 0, 12'h000, 0);  // R4 count 0 -> 1
        run_txn(3'd7, 32'h4433_2211, 8'h55, 5'h1F, 0, 0, 12'h000, 0);  // R4 count 7 -> 5
        run_txn(3'd1, 32'h0000_009F, 8'h00, 5'h01, 2, 3, 12'h100, 0);  // R7 + R8 together
        run_txn(3'd1, 32'h0000_0006, 8'h00, 5'h01, 0, 3, 12'h400, 1);  // R10 busy launch

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * CLK_P);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule